// File: doc/BRIEF.md
# Banked External Interrupt Aggregator

This block collects 64 external interrupt lines and presents them to a parent interrupt controller as a single request. The lines are split into two banks of 32. Source n belongs to bank n/32 at bit position n%32. Every line passes through a two-flop synchroniser. After that, a per-source trigger selection decides how it is judged: as a high level, as a low level, as a rising edge or as a falling edge. Edge events are latched into a sticky pending bit. Level sources show the current active state of their input.

Software uses a plain single-cycle 32-bit register port with an address, a write strobe, write data and combinational read data. Each bank has its own 32-byte window, and the windows are laid out one after the other. Inside a window, software can set:

- the trigger selection fields;
- a per-source block bit;
- a per-source clear bit.

It can also read the pending status. A clear bit is used as a pulse: software writes 1 and then 0. While the clear bit reads 1, that source is kept idle. The pulse also puts the edge history in a clean state after a trigger change, so the change does not look like an edge. The output request is the OR of all pending bits that are not blocked, and it is registered.

Top module: `ext_irq_aggregator`

## Requirements
- R1: After reset, every trigger field is 0, every block bit is 1, every clear bit is 0, every pending bit is 0 and `irq_out` is 0.
- R2: Bank b uses byte addresses b*0x20 to b*0x20+0x1F. Inside the window the registers are:
  - 0x04: trigger fields for bits 0 to 15;
  - 0x08: trigger fields for bits 16 to 31;
  - 0x10: clear register;
  - 0x14: block register;
  - 0x1C: status register.
  In the trigger words, the field of bit k sits at bits [2*(k%16)+1 : 2*(k%16)]. The trigger, clear and block registers read back the value that was last written.
- R3: Any other offset, and any address beyond the last bank, reads 0. Writes to the status offset change nothing.
- R4: Trigger field encodings are: 0 = level, active high; 1 = level, active low; 2 = rising edge; 3 = falling edge.
- R5: For the edge encodings (2 and 3), the pending bit sets on the selected edge of the synchronised input. It stays set until that source is cleared, even after the input returns to its previous level.
- R6: For the level encodings (0 and 1), the pending bit equals the active state of the synchronised input. It drops when the input goes inactive.
- R7: While a source's clear bit is 1, its pending bit is 0. An edge that occurs while the clear bit is held is not latched after the clear bit is released.
- R8: If software changes a source's trigger field and then pulses its clear bit, the edge-type source ends with pending 0, even when the input did not move.
- R9: Status reports pending regardless of the block bit. A source whose block bit is 1 never raises `irq_out`.
- R10: `irq_out` is the registered OR of all pending bits whose block bit is 0. When an input change is applied, the change appears in status after 3 rising clock edges and on `irq_out` after 4 rising clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_src | input | 64 | External interrupt lines, asynchronous to clk |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Write strobe; write data is taken at the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_out | output | 1 | Combined request to the parent controller |

## Verification
The bench checks the following corner cases:

- **Clear held while an edge arrives.** If the design let the history freeze, or drop to zero during the hold, a false pending bit would appear when the clear is released.
- **Rising-to-falling change on a steady input.** If the clear pulse did not settle the history, pending would be left set with no real edge.
- **Exact cycle count from input to status and output.** A missing or extra synchroniser stage would move the change by one edge.
- **Edge pending after the input returns.** A design that treated edges like levels would lose the pending bit.
- **Pending on a blocked source.** The status must still show it while `irq_out` stays low.

It also targets the last source of the upper bank, so that a wrong field offset or a wrong window stride shows up. Random sequences of line changes, block writes, whole-word trigger rewrites and clear pulses are compared against a bench model of pending and output.

// File: rtl/eirq_pkg.sv
// Shared constants and types for the banked external interrupt aggregator.
// Assumes a fixed 32-byte register window per bank with 32-bit registers.
package eirq_pkg;

    localparam int TRIG_W  = 2;
    localparam int WIN_LG2 = 5;

    localparam logic [WIN_LG2-1:0] OFS_TRIG_BASE = 5'h04;
    localparam logic [WIN_LG2-1:0] OFS_CLEAR     = 5'h10;
    localparam logic [WIN_LG2-1:0] OFS_BLOCK     = 5'h14;
    localparam logic [WIN_LG2-1:0] OFS_STATUS    = 5'h1C;

    typedef enum logic [TRIG_W-1:0] {
        TRIG_LVL_HI = 2'd0,
        TRIG_LVL_LO = 2'd1,
        TRIG_RISE   = 2'd2,
        TRIG_FALL   = 2'd3
    } trig_t;

endpackage

// File: rtl/eirq_sync.sv
// Two-flop synchroniser for a vector of asynchronous lines.
// Assumes each line is a slow, independent level; there is no bus coherency.
module eirq_sync #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Move each line through two flops before anything else looks at it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

endmodule

// File: rtl/eirq_detect.sv
// Per-source trigger evaluation and pending latch.
// The history flop keeps the polarity-adjusted sample of the line. A trigger
// change can therefore look like an edge; the clear input makes the pending
// flop idle while the history keeps following the line, so that releasing
// the clear never produces an edge.
// Assumes lvl is already synchronised to clk.
module eirq_detect
    import eirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lvl,
    input  logic [TRIG_W-1:0] trig,
    input  logic              clr,
    output logic              pend
);

    trig_t sel;
    logic  act;
    logic  is_edge;
    logic  hist_q;
    logic  pend_q;

    // Decode the trigger selection into polarity and level/edge class.
    always_comb begin
        sel     = trig_t'(trig);
        act     = (sel == TRIG_LVL_LO || sel == TRIG_FALL) ? ~lvl : lvl;
        is_edge = (sel == TRIG_RISE || sel == TRIG_FALL);
    end

    // Track history and update pending according to the class and the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            hist_q <= act;
            if (clr) begin
                pend_q <= 1'b0;
            end else if (is_edge) begin
                pend_q <= pend_q | (act & ~hist_q);
            end else begin
                pend_q <= act;
            end
        end
    end

    assign pend = pend_q;

endmodule

// File: rtl/eirq_bank.sv
// One bank of sources: register window decode, trigger words, clear and
// block registers, per-source detectors and the read path for the window.
// Assumes SRC_N is a multiple of DATA_W/TRIG_W and fits in one data word.
module eirq_bank
    import eirq_pkg::*;
#(
    parameter int SRC_N  = 32,
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel,
    input  logic               wr_en,
    input  logic [WIN_LG2-1:0] ofs,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [SRC_N-1:0]   src_lvl,
    output logic [DATA_W-1:0]  rd_data,
    output logic [SRC_N-1:0]   pend,
    output logic [SRC_N-1:0]   block,
    output logic [SRC_N-1:0]   clr,
    output logic [SRC_N-1:0]   edge_kind
);

    localparam int SRC_PER_WORD = DATA_W / TRIG_W;
    localparam int TRIG_WORDS   = SRC_N / SRC_PER_WORD;

    logic [DATA_W-1:0] trig_q [TRIG_WORDS];
    logic [SRC_N-1:0]  clr_q;
    logic [SRC_N-1:0]  block_q;

    // Register writes for this window; status is read-only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < TRIG_WORDS; w++) begin
                trig_q[w] <= '0;
            end
            clr_q   <= '0;
            block_q <= '1;
        end else if (sel && wr_en) begin
            if (ofs == OFS_CLEAR) begin
                clr_q <= wr_data[SRC_N-1:0];
            end
            if (ofs == OFS_BLOCK) begin
                block_q <= wr_data[SRC_N-1:0];
            end
            for (int w = 0; w < TRIG_WORDS; w++) begin
                if (ofs == OFS_TRIG_BASE + WIN_LG2'(4 * w)) begin
                    trig_q[w] <= wr_data;
                end
            end
        end
    end

    // One detector per source, fed by its field of the trigger words.
    for (genvar i = 0; i < SRC_N; i++) begin : g_src
        logic [TRIG_W-1:0] fld;
        assign fld = trig_q[i / SRC_PER_WORD][TRIG_W * (i % SRC_PER_WORD) +: TRIG_W];
        assign edge_kind[i] = fld[1];

        eirq_detect u_det (
            .clk  (clk),
            .rst_n(rst_n),
            .lvl  (src_lvl[i]),
            .trig (fld),
            .clr  (clr_q[i]),
            .pend (pend[i])
        );
    end

    // Read path: drives zero unless this window is addressed at a mapped offset.
    always_comb begin
        rd_data = '0;
        if (sel) begin
            if (ofs == OFS_CLEAR) begin
                rd_data = DATA_W'(clr_q);
            end
            if (ofs == OFS_BLOCK) begin
                rd_data = DATA_W'(block_q);
            end
            if (ofs == OFS_STATUS) begin
                rd_data = DATA_W'(pend);
            end
            for (int w = 0; w < TRIG_WORDS; w++) begin
                if (ofs == OFS_TRIG_BASE + WIN_LG2'(4 * w)) begin
                    rd_data = trig_q[w];
                end
            end
        end
    end

    assign clr   = clr_q;
    assign block = block_q;

endmodule

// File: rtl/ext_irq_aggregator.sv
// Top of the banked external interrupt aggregator. It synchronises all
// lines, instantiates one bank per register window, merges the read data and
// registers the OR of unblocked pending bits towards the parent controller.
// Assumes single-cycle register accesses and ADDR_W wide enough for all banks.
module ext_irq_aggregator
    import eirq_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int SRC_N     = 32,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_BANKS*SRC_N-1:0]   irq_src,
    input  logic [ADDR_W-1:0]            reg_addr,
    input  logic                         reg_wr,
    input  logic [DATA_W-1:0]            reg_wdata,
    output logic [DATA_W-1:0]            reg_rdata,
    output logic                         irq_out
);

    localparam int NUM_SRC = NUM_BANKS * SRC_N;
    localparam int BSEL_W  = ADDR_W - WIN_LG2;

    logic [NUM_SRC-1:0] src_sync;
    logic [NUM_SRC-1:0] pend_flat;
    logic [NUM_SRC-1:0] block_flat;
    logic [NUM_SRC-1:0] clr_flat;
    logic [NUM_SRC-1:0] edge_flat;
    logic [DATA_W-1:0]  bank_rd [NUM_BANKS];
    logic               irq_q;

    eirq_sync #(.W(NUM_SRC)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(irq_src),
        .sync_out(src_sync)
    );

    // One bank per register window, selected by the upper address bits.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = (reg_addr[ADDR_W-1:WIN_LG2] == BSEL_W'(b));

        eirq_bank #(.SRC_N(SRC_N), .DATA_W(DATA_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel      (hit),
            .wr_en    (reg_wr),
            .ofs      (reg_addr[WIN_LG2-1:0]),
            .wr_data  (reg_wdata),
            .src_lvl  (src_sync[b*SRC_N +: SRC_N]),
            .rd_data  (bank_rd[b]),
            .pend     (pend_flat[b*SRC_N +: SRC_N]),
            .block    (block_flat[b*SRC_N +: SRC_N]),
            .clr      (clr_flat[b*SRC_N +: SRC_N]),
            .edge_kind(edge_flat[b*SRC_N +: SRC_N])
        );
    end

    // Merge bank read data; at most one bank drives a non-zero value.
    always_comb begin
        reg_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            reg_rdata = reg_rdata | bank_rd[b];
        end
    end

    // Register the combined request for the parent controller.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |(pend_flat & ~block_flat);
        end
    end

    assign irq_out = irq_q;

endmodule

// File: rtl/eirq_checker.sv
// Property checks for ext_irq_aggregator, attached with bind.
module eirq_checker #(
    parameter int NUM_SRC = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               irq_out,
    input logic [NUM_SRC-1:0] pend_flat,
    input logic [NUM_SRC-1:0] block_flat,
    input logic [NUM_SRC-1:0] clr_flat,
    input logic [NUM_SRC-1:0] edge_flat
);

    // R1
    reset_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (block_flat == '1 && pend_flat == '0 && clr_flat == '0 && !irq_out));

    // R7
    clear_idles_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_flat & $past(clr_flat)) == '0);

    // R5
    edge_pending_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pend_flat) & ~pend_flat & $past(edge_flat) & ~$past(clr_flat)) == '0);

    // R10
    output_tracks_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (|$past(pend_flat & ~block_flat)));

endmodule

bind ext_irq_aggregator eirq_checker #(.NUM_SRC(NUM_BANKS * SRC_N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_out   (irq_out),
    .pend_flat (pend_flat),
    .block_flat(block_flat),
    .clr_flat  (clr_flat),
    .edge_flat (edge_flat)
);

// File: tb/ext_irq_aggregator_tb.sv
module ext_irq_aggregator_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_src = '0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_out;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    logic [1:0]  m_type [NS];
    logic [63:0] m_in = '0;
    logic [63:0] m_mask = '1;
    logic [63:0] m_pend = '0;
    logic [63:0] m_clr = '0;

    ext_irq_aggregator u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_src  (irq_src),
        .reg_addr (reg_addr),
        .reg_wr   (reg_wr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .irq_out  (irq_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic act_of(logic [1:0] t, logic v);
        return t[0] ? ~v : v;
    endfunction

    function automatic logic exp_out();
        return |(m_pend & ~m_mask);
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic settle();
        repeat (6) @(posedge clk);
    endtask

    task automatic drive(logic [63:0] nv);
        for (int i = 0; i < NS; i++) begin
            logic oa, na;
            oa = act_of(m_type[i], m_in[i]);
            na = act_of(m_type[i], nv[i]);
            if (m_clr[i]) m_pend[i] = 1'b0;
            else if (m_type[i][1]) m_pend[i] = m_pend[i] | (na & ~oa);
            else m_pend[i] = na;
        end
        m_in = nv;
        @(negedge clk);
        irq_src = nv;
    endtask

    task automatic clear_set(int b, logic [31:0] bits);
        m_clr[b*32 +: 32] = m_clr[b*32 +: 32] | bits;
        m_pend[b*32 +: 32] = m_pend[b*32 +: 32] & ~bits;
        wr(8'(b * 32 + 16), m_clr[b*32 +: 32]);
    endtask

    task automatic clear_rel(int b, logic [31:0] bits);
        m_clr[b*32 +: 32] = m_clr[b*32 +: 32] & ~bits;
        for (int k = 0; k < 32; k++) begin
            if (bits[k]) begin
                int s;
                s = b * 32 + k;
                m_pend[s] = m_type[s][1] ? 1'b0 : act_of(m_type[s], m_in[s]);
            end
        end
        wr(8'(b * 32 + 16), m_clr[b*32 +: 32]);
    endtask

    task automatic clear_pulse(int b, logic [31:0] bits);
        clear_set(b, bits);
        clear_rel(b, bits);
    endtask

    task automatic write_trig_word(int b, int w);
        logic [31:0] word;
        for (int k = 0; k < 16; k++) word[2*k +: 2] = m_type[b*32 + w*16 + k];
        wr(8'(b * 32 + 4 + 4 * w), word);
    endtask

    task automatic set_type(int src, logic [1:0] t);
        m_type[src] = t;
        write_trig_word(src / 32, (src % 32) / 16);
        clear_pulse(src / 32, 32'h1 << (src % 32));
    endtask

    task automatic set_mask(int b, logic [31:0] v);
        m_mask[b*32 +: 32] = v;
        wr(8'(b * 32 + 20), v);
    endtask

    task automatic check_all(string req_s, string req_o);
        logic [31:0] d;
        rd(8'h1C, d); chk(req_s, d, m_pend[31:0]);
        rd(8'h3C, d); chk(req_s, d, m_pend[63:32]);
        chk(req_o, {31'd0, irq_out}, {31'd0, exp_out()});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < NS; i++) m_type[i] = 2'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h04, d); chk("R1", d, 32'h0);
        rd(8'h28, d); chk("R1", d, 32'h0);
        rd(8'h14, d); chk("R1", d, 32'hFFFF_FFFF);
        rd(8'h34, d); chk("R1", d, 32'hFFFF_FFFF);
        rd(8'h1C, d); chk("R1", d, 32'h0);
        rd(8'h10, d); chk("R1", d, 32'h0);
        chk("R1", {31'd0, irq_out}, 32'h0);

        // R2 map, field position of source 63, readback
        set_type(63, 2'd3);
        rd(8'h28, d); chk("R2", d, 32'hC000_0000);
        rd(8'h08, d); chk("R2", d, 32'h0);
        set_mask(0, 32'hFFFF_FFF0);
        rd(8'h14, d); chk("R2", d, 32'hFFFF_FFF0);
        clear_set(0, 32'h100);
        rd(8'h10, d); chk("R2", d, 32'h100);
        clear_rel(0, 32'h100);

        // R10 latency: 3 edges to status, 4 edges to irq_out
        @(negedge clk);
        irq_src[0] = 1'b1; m_in[0] = 1'b1; m_pend[0] = 1'b1;
        repeat (2) @(posedge clk);
        rd(8'h1C, d); chk("R10", d, 32'h0);
        @(posedge clk);
        rd(8'h1C, d); chk("R10", d, 32'h1);
        chk("R10", {31'd0, irq_out}, 32'h0);
        @(posedge clk);
        @(negedge clk);
        chk("R10", {31'd0, irq_out}, 32'h1);

        // R6 level drops with input
        drive(m_in & ~64'h1); settle();
        rd(8'h1C, d); chk("R6", d, 32'h0);
        chk("R6", {31'd0, irq_out}, 32'h0);

        // R4 active-low level
        set_type(1, 2'd1); settle();
        rd(8'h1C, d); chk("R4", d, 32'h2);
        chk("R4", {31'd0, irq_out}, 32'h1);
        drive(m_in | 64'h2); settle();
        rd(8'h1C, d); chk("R4", d, 32'h0);

        // R5 rising edge is sticky
        set_type(2, 2'd2);
        drive(m_in | 64'h4); settle();
        drive(m_in & ~64'h4); settle();
        rd(8'h1C, d); chk("R5", d, 32'h4);
        clear_pulse(0, 32'h4); settle();
        rd(8'h1C, d); chk("R5", d, 32'h0);

        // R4 falling edge on source 63, R9 block behaviour
        drive(m_in | (64'h1 << 63)); settle();
        drive(m_in & ~(64'h1 << 63)); settle();
        rd(8'h3C, d); chk("R4", d, 32'h8000_0000);
        chk("R9", {31'd0, irq_out}, 32'h0);
        set_mask(1, 32'h7FFF_FFFF); settle();
        chk("R9", {31'd0, irq_out}, 32'h1);
        clear_pulse(1, 32'h8000_0000); settle();
        chk("R9", {31'd0, irq_out}, 32'h0);

        // R7 edge during held clear is not latched
        clear_set(0, 32'h4);
        drive(m_in | 64'h4); settle();
        rd(8'h1C, d); chk("R7", d, 32'h0);
        clear_rel(0, 32'h4); settle();
        rd(8'h1C, d); chk("R7", d, 32'h0);
        drive(m_in & ~64'h4); settle();

        // R8 rising -> falling on a steady low input, then clear
        set_type(3, 2'd2); settle();
        set_type(3, 2'd3); settle();
        rd(8'h1C, d); chk("R8", d, 32'h0);
        chk("R8", {31'd0, irq_out}, 32'h0);

        // R3 unmapped offsets and status write
        rd(8'h00, d); chk("R3", d, 32'h0);
        rd(8'h0C, d); chk("R3", d, 32'h0);
        rd(8'h18, d); chk("R3", d, 32'h0);
        rd(8'h40, d); chk("R3", d, 32'h0);
        rd(8'hFC, d); chk("R3", d, 32'h0);
        wr(8'h1C, 32'hFFFF_FFFF);
        rd(8'h1C, d); chk("R3", d, m_pend[31:0]);

        // Random phase against the model (R4, R5, R6, R9)
        for (int it = 0; it < 60; it++) begin
            int op, b;
            op = int'($urandom % 4);
            b = int'($urandom % 2);
            case (op)
                0: drive({$urandom, $urandom});
                1: set_mask(b, $urandom);
                2: begin
                    int w;
                    logic [31:0] v;
                    w = int'($urandom % 2);
                    v = $urandom;
                    for (int k = 0; k < 16; k++) m_type[b*32 + w*16 + k] = v[2*k +: 2];
                    write_trig_word(b, w);
                    clear_pulse(b, 32'hFFFF_FFFF);
                end
                default: clear_pulse(b, $urandom);
            endcase
            settle();
            check_all("R4", "R9");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule